// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Address Filter

This block receives asynchronous serial frames from an input pin that has already been synchronized to the system clock. The bit timing comes from an external oversampling tick that pulses sixteen times per bit period. Each frame has the following parts:

- a low start bit;
- eight data bits, least significant first;
- an optional ninth bit;
- a high stop bit.

Finished frames go into a two-entry receive queue. The host pops that queue with a one-cycle read strobe. An interrupt request stays high while the queue holds anything.

In nine-bit mode an address filter can be switched on. When it is on, only frames whose ninth bit is 1 are kept, so a node on a shared line wakes only for address frames. When the filter is off, every frame is kept and the ninth bit is handed to the host unchanged. Software may use that bit as parity; the hardware does not check it.

A framing flag travels with each queued frame and is reported for the frame at the head of the queue. An overrun flag latches when a frame finishes while the queue is full. The flag then blocks further frames until the receive enable is dropped.

The frame engine is a state machine with six states:

- IDLE waits for a low level on a tick, then goes to START.
- START counts half a bit. If the line is still low it goes to DATA; otherwise it returns to IDLE.
- DATA samples eight bit centres. After the last one it goes to NINTH in nine-bit mode, or to STOP otherwise.
- NINTH samples one centre and then goes to STOP.
- STOP samples the stop centre. It goes to IDLE if the line is high, or to WAITHI if it is low.
- WAITHI returns to IDLE once the line is high.

Clearing either enable forces IDLE from any state.

Top module: `uart_addr_rx`

## Requirements
- R1: While `port_en` is 0 the queue is empty, `irq` and `overrun` are 0, and frames on `rxd` are ignored.
- R2: While `rx_en` is 0 (with `port_en` 1) frames on `rxd` are not received.
- R3: A frame is a low start bit, then 8 data bits LSB first, then a ninth bit only when `frame9`=1, then a stop bit. Each bit lasts 16 `tick` pulses and is sampled at its centre.
- R4: A low pulse on `rxd` that is high again at the start bit's centre (8 ticks after it is seen) produces no frame.
- R5: With `frame9`=1 and `addr_det`=1, a frame is stored only if its ninth bit is 1. Otherwise it is discarded and `irq` is unaffected.
- R6: With `frame9`=0, `addr_det` has no effect: every frame is stored and `rd_bit9` reads 0.
- R7: With `frame9`=1 and `addr_det`=0, every frame is stored and `rd_bit9` equals the received ninth bit.
- R8: `frame_err` is 1 when the head frame's stop bit was sampled low. It changes to the next frame's flag when the head is read.
- R9: The queue holds 2 frames. `irq` equals "queue not empty". `rd_data` and `rd_bit9` show the head, and read 0 when the queue is empty. A `rd_strobe` pulse pops one frame; a strobe on an empty queue has no effect.
- R10: A frame that finishes while the queue is full and is not being read is lost and sets `overrun`. While `overrun` is 1, no further frame is stored.
- R11: `overrun` stays 1 until `rx_en` (or `port_en`) is 0; clearing it does not disturb queued frames.
- R12: After reset every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Block enable; 0 holds everything cleared |
| rx_en | input | 1 | Receive enable; 0 stops reception and clears overrun |
| frame9 | input | 1 | 1 selects nine-bit frames, 0 eight-bit |
| addr_det | input | 1 | Address filter enable (nine-bit mode only) |
| tick | input | 1 | Oversampling pulse, 16 per bit |
| rxd | input | 1 | Synchronized serial input, idle high |
| rd_strobe | input | 1 | Pops the head frame |
| rd_data | output | 8 | Head frame data |
| rd_bit9 | output | 1 | Head frame ninth bit |
| frame_err | output | 1 | Head frame framing error |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Data-available request |

## Verification
On every cycle, the assertions check these properties:

- a disabled block is parked in IDLE and shows nothing;
- the overrun flag stays set while reception is enabled, and never lets a frame into the queue;
- the queue level never exceeds its depth;
- the head outputs are quiet whenever the queue is empty.

Only the bench scenarios can show the remaining behaviour:

- bit order and centre sampling;
- rejection of start glitches;
- the address filter, compared with the pass-through of the ninth bit;
- the framing flag advancing from one frame to the next;
- loss of the third frame, followed by recovery after the receive enable is dropped.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int RX_DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP,
        RX_WAITHI
    } rx_state_t;

    typedef struct packed {
        logic                 ferr;
        logic                 b9;
        logic [RX_DATA_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = RX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rxd,
    input  logic              frame9,
    output logic              done,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              ferr_o
);

    localparam int CNT_W = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DATA_W - 1);

    rx_state_t         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              b9;
    logic              centre;

    assign centre = tick && (cnt == LAST);

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (tick && !rxd) nxt = RX_START;
            RX_START:  if (tick && cnt == HALF_M1) nxt = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:   if (centre && idx == IDX_END) nxt = frame9 ? RX_NINTH : RX_STOP;
            RX_NINTH:  if (centre) nxt = RX_STOP;
            RX_STOP:   if (centre) nxt = rxd ? RX_IDLE : RX_WAITHI;
            RX_WAITHI: if (rxd) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
        if (!en) nxt = RX_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // bit timing and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            idx <= '0;
            sh  <= '0;
            b9  <= 1'b0;
        end else if (!en || state != nxt) begin
            cnt <= '0;
            if (state == RX_IDLE) b9 <= 1'b0;
            if (state == RX_START) idx <= '0;
            if (state == RX_DATA && centre) sh <= {rxd, sh[DATA_W-1:1]};
            if (state == RX_NINTH && centre) b9 <= rxd;
        end else if (tick && state != RX_IDLE && state != RX_WAITHI) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (state == RX_DATA && centre) begin
                sh  <= {rxd, sh[DATA_W-1:1]};
                idx <= idx + 1'b1;
            end
        end
    end

    // frame outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            data_o <= '0;
            bit9_o <= 1'b0;
            ferr_o <= 1'b0;
        end else begin
            done <= 1'b0;
            if (en && state == RX_STOP && centre) begin
                done   <= 1'b1;
                data_o <= sh;
                bit9_o <= b9;
                ferr_o <= !rxd;
            end
        end
    end

    // R2: a disabled receiver is parked in IDLE on the next cycle
    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == RX_IDLE));

    // R3: the bit index never runs past the data width while shifting
    assert_bitidx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA) |-> (idx < IDX_W'(DATA_W)));

    // R6: an eight-bit frame never reports a ninth bit
    assert_no_bit9_8bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && !frame9 && $stable(frame9)) |-> !b9);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      wr,
    input  rx_entry_t wdata,
    input  logic      rd,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [LVL_W-1:0] lvl;
    logic             do_wr, do_rd;

    assign empty = (lvl == '0);
    assign full  = (lvl == LVL_W'(DEPTH));
    assign do_rd = rd && !empty;
    assign do_wr = wr && (!full || do_rd);
    assign head  = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else begin
            if (do_wr) wp <= (wp == PTR_MAX) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == PTR_MAX) ? '0 : rp + 1'b1;
            if (do_wr && !do_rd) lvl <= lvl + 1'b1;
            else if (do_rd && !do_wr) lvl <= lvl - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem[g] <= '0;
            else if (do_wr && !clr && wp == PTR_W'(g)) mem[g] <= wdata;
        end
    end

    // R9: the level never exceeds the depth
    assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LVL_W'(DEPTH));

    // R10: the control logic never writes into a full queue that is not being read
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full) |-> rd);

endmodule

// File: rtl/uart_rx_gate.sv
module uart_rx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic rx_en,
    input  logic frame9,
    input  logic addr_det,
    input  logic done,
    input  logic bit9,
    input  logic full,
    input  logic rd,
    output logic push,
    output logic overrun
);

    logic keep;

    assign keep = done && (!frame9 || !addr_det || bit9);
    assign push = keep && !overrun && (!full || rd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  overrun <= 1'b0;
        else if (!port_en || !rx_en) overrun <= 1'b0;
        else if (keep && full && !rd) overrun <= 1'b1;
    end

    // R11: overrun stays set while both enables stay high
    assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && port_en && rx_en) |=> overrun);

    // R10: nothing enters the queue while overrun is set
    assert_no_push_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !push);

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_en,
    input  logic                 rx_en,
    input  logic                 frame9,
    input  logic                 addr_det,
    input  logic                 tick,
    input  logic                 rxd,
    input  logic                 rd_strobe,
    output logic [RX_DATA_W-1:0] rd_data,
    output logic                 rd_bit9,
    output logic                 frame_err,
    output logic                 overrun,
    output logic                 irq
);

    logic                 en, done, f_b9, f_ferr, push, empty, full, rd;
    logic [RX_DATA_W-1:0] f_data;
    rx_entry_t            wentry, head;

    assign en = port_en && rx_en;
    assign rd = rd_strobe && port_en && !empty;

    uart_rx_fsm #(.OVS(OVS), .DATA_W(RX_DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .rxd(rxd),
        .frame9(frame9), .done(done), .data_o(f_data), .bit9_o(f_b9),
        .ferr_o(f_ferr)
    );

    uart_rx_gate u_gate (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_en(rx_en),
        .frame9(frame9), .addr_det(addr_det), .done(done), .bit9(f_b9),
        .full(full), .rd(rd), .push(push), .overrun(overrun)
    );

    assign wentry = '{ferr: f_ferr, b9: f_b9, data: f_data};

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(!port_en), .wr(push), .wdata(wentry),
        .rd(rd), .head(head), .empty(empty), .full(full)
    );

    always_comb begin
        irq       = !empty;
        rd_data   = empty ? '0 : head.data;
        rd_bit9   = !empty && head.b9;
        frame_err = !empty && head.ferr;
    end

    // R1: a disabled port shows no request and no overrun
    assert_port_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!irq && !overrun));

    // R9: head outputs are quiet when no request is raised
    assert_quiet_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (!frame_err && !rd_bit9 && rd_data == '0));

endmodule

// File: tb/uart_addr_rx_test.sv
module uart_addr_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, rx_en = 1'b0, frame9 = 1'b0, addr_det = 1'b0;
    logic       tick = 1'b0, rxd = 1'b1, rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, frame_err, overrun, irq;
    int         total = 0, bad = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    uart_addr_rx uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_en(rx_en),
        .frame9(frame9), .addr_det(addr_det), .tick(tick), .rxd(rxd),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_bit9(rd_bit9),
        .frame_err(frame_err), .overrun(overrun), .irq(irq)
    );

    // {frame9, addr_det, data[7:0], ninth, stop_ok, stored}
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1},  // R3 R6 eight-bit
        {1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1},  // R6 filter ignored
        {1'b1, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b1},  // R7 ninth 0 kept
        {1'b1, 1'b0, 8'hC3, 1'b1, 1'b1, 1'b1},  // R7 ninth 1 kept
        {1'b1, 1'b1, 8'h77, 1'b0, 1'b1, 1'b0},  // R5 data frame dropped
        {1'b1, 1'b1, 8'h81, 1'b1, 1'b1, 1'b1},  // R5 address frame kept
        {1'b0, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b1},  // R8 bad stop
        {1'b1, 1'b1, 8'hE2, 1'b1, 1'b0, 1'b1}   // R5 R8 bad stop, address
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (32) @(negedge clk);
    endtask

    task automatic send(input logic nine9, input logic [7:0] d, input logic nb, input logic stop_ok);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (nine9) hold_bit(nb);
        hold_bit(stop_ok);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic pop();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset values
        chk("R12 irq", irq, 0);
        chk("R12 rd_data", rd_data, 0);
        chk("R12 frame_err", frame_err, 0);
        chk("R12 overrun", overrun, 0);
        rst_n = 1'b1;
        port_en = 1'b1;
        rx_en = 1'b1;

        // table walk
        foreach (VEC[k]) begin
            frame9 = VEC[k][12];
            addr_det = VEC[k][11];
            send(VEC[k][12], VEC[k][10:3], VEC[k][2], VEC[k][1]);
            chk("R3/R5 stored", irq, VEC[k][0]);
            if (VEC[k][0]) begin
                chk("R3 data", rd_data, VEC[k][10:3]);
                chk("R6/R7 bit9", rd_bit9, VEC[k][12] & VEC[k][2]);
                chk("R8 ferr", frame_err, !VEC[k][1]);
                pop();
                chk("R9 popped", irq, 0);
            end
        end

        // R4 start glitch
        frame9 = 1'b0;
        addr_det = 1'b0;
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (400) @(negedge clk);
        chk("R4 glitch", irq, 0);

        // R9 strobe on empty
        pop();
        chk("R9 empty pop", irq, 0);

        // R8 R9 R10 R11 queue fill and overrun
        send(1'b0, 8'h11, 1'b0, 1'b0);
        send(1'b0, 8'h22, 1'b0, 1'b1);
        chk("R10 no overrun at two", overrun, 0);
        send(1'b0, 8'h33, 1'b0, 1'b1);
        chk("R10 overrun set", overrun, 1);
        chk("R9 irq full", irq, 1);
        chk("R10 head kept", rd_data, 8'h11);
        chk("R8 head ferr", frame_err, 1);
        pop();
        chk("R8 next head", rd_data, 8'h22);
        chk("R8 ferr advances", frame_err, 0);
        pop();
        chk("R10 third lost", irq, 0);
        send(1'b0, 8'h44, 1'b0, 1'b1);
        chk("R10 blocked", irq, 0);
        chk("R11 sticky", overrun, 1);

        // R11 clear with queued frame untouched
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R11 cleared", overrun, 0);
        send(1'b0, 8'h55, 1'b0, 1'b1);
        chk("R11 receives again", rd_data, 8'h55);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 queue kept", rd_data, 8'h55);

        // R2 receive disabled
        pop();
        send(1'b0, 8'h66, 1'b0, 1'b1);
        chk("R2 ignored", irq, 0);
        rx_en = 1'b1;

        // R1 port disable flushes and ignores
        send(1'b0, 8'h77, 1'b0, 1'b1);
        chk("R1 pre", irq, 1);
        port_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 flushed", irq, 0);
        send(1'b0, 8'h88, 1'b0, 1'b1);
        chk("R1 ignored", irq, 0);
        chk("R1 rd_data", rd_data, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule